// File: doc/BRIEF.md
# Flash Status Word Generator

This block sits on the device side of a NAND flash interface and produces the word returned when the host reads status. It records the kind of array operation in progress. It keeps the pass/fail outcome of program and erase work and turns live busy and write-protect conditions into a status word. For cache programming it keeps two generations of results, one for the page that just finished and one for the page before it. It reports the cache register's readiness separately from the array's true readiness.

The command decoder sends the block four kinds of pulse:
- status-entry pulses;
- status-exit pulses;
- operation-start pulses, each carrying an operation code;
- operation-finish pulses, each carrying a fail flag.

The array controller drives two busy levels, one for the array and one for the cache. The write-protect pin and the bus-width mode come straight in. While status mode is active, the output word is rebuilt every cycle, so polling needs no fresh read strobe.

Top module: `nsr_status_gen`

## Requirements
- R1: While reset is high and on the cycle after it, `stat_word` is zero and `stat_hi_oe` is low. Reset leaves both result bits at pass and the recorded mode at read.
- R2: Bit 0 of `stat_word` is the result of the latest program or erase (1 = fail, 0 = pass). It reads 0 while the recorded mode is read.
- R3: In cache mode (code 3), each `op_done` moves the old bit 0 result into bit 1 and loads `op_fail` into bit 0. Outside cache mode, bit 1 reads 0.
- R4: Bit 5 is the inverse of `array_busy` (1 = ready) in every mode.
- R5: Bit 6 is the inverse of `cache_busy` in cache mode and the inverse of `array_busy` in all other modes.
- R6: Bit 7 equals `wp_n` (0 = protected).
- R7: Bits 2 to 4 and bits 15 to 8 always read 0. `stat_hi_oe` is high exactly when status mode is active and `wide_mode` was high.
- R8: Status mode becomes active on the edge where `stat_enter` is high. It becomes inactive on the edge where `stat_exit` is high, and exit wins when both are high. While status mode is inactive, the word is 0.
- R9: The word has a latency of one register. It reflects the inputs and state sampled at the previous edge, with no strobe needed.
- R10: The operation codes are 0 = read, 1 = page program, 2 = block erase and 3 = cache program. An `op_start` with code 1 or 2 clears both result bits to pass. Code 0 or code 3 leaves both result bits unchanged. Every `op_start` records its code as the mode.
- R11: An `op_done` in the same cycle as `op_start` is ignored. An `op_done` while the mode is read leaves the result bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| op_start | input | 1 | pulse: an array operation begins |
| op_code | input | 2 | operation code qualified by op_start |
| op_done | input | 1 | pulse: the array operation finished |
| op_fail | input | 1 | fail flag qualified by op_done |
| array_busy | input | 1 | array operation in progress |
| cache_busy | input | 1 | cache register not yet free |
| wp_n | input | 1 | write-protect pin, low = protected |
| wide_mode | input | 1 | 16-bit bus mode |
| stat_enter | input | 1 | pulse: status read command decoded |
| stat_exit | input | 1 | pulse: another command decoded |
| stat_word | output | 16 | status word |
| stat_hi_oe | output | 1 | upper byte is driven |

## Verification
The assertions assume three things about the inputs. `op_start`, `op_done`, `stat_enter` and `stat_exit` are single-cycle qualifiers. `op_code` and `op_fail` matter only alongside their qualifiers. Both busy inputs are plain levels. The stimulus drives every input on the falling edge. Directed phases cover cache pipelines, clears on start, and collisions between enter and exit and between start and done. A random phase then holds each pulse at a low rate and varies the levels freely.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    typedef enum logic [1:0] {
        OPK_READ  = 2'd0,
        OPK_PROG  = 2'd1,
        OPK_ERASE = 2'd2,
        OPK_CACHE = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic prev;   // result of page N-1 (cache only)
        logic cur;    // result of current page / operation
    } pf_pair_t;

    typedef struct packed {
        logic array_busy;
        logic cache_busy;
        logic wp_n;
    } live_in_t;

    localparam int BYTE_W     = 8;
    localparam int POS_CUR    = 0;
    localparam int POS_PREV   = 1;
    localparam int POS_TRUE   = 5;
    localparam int POS_HOST   = 6;
    localparam int POS_WP     = 7;

    function automatic logic clears_results(op_kind_e k);
        return (k == OPK_PROG) || (k == OPK_ERASE);
    endfunction

    function automatic logic [BYTE_W-1:0] build_low(op_kind_e mode, pf_pair_t pf, live_in_t li);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[POS_CUR]  = (mode != OPK_READ) ? pf.cur : 1'b0;
        b[POS_PREV] = (mode == OPK_CACHE) ? pf.prev : 1'b0;
        b[POS_TRUE] = ~li.array_busy;
        b[POS_HOST] = (mode == OPK_CACHE) ? ~li.cache_busy : ~li.array_busy;
        b[POS_WP]   = li.wp_n;
        return b;
    endfunction

endpackage

// File: rtl/nsr_mode_track.sv
module nsr_mode_track
    import nsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_start,
    input  logic [1:0] op_code,
    output op_kind_e mode_q,
    output logic     clr_pf
);
    op_kind_e code_k;

    always_comb begin
        code_k = op_kind_e'(op_code);
        clr_pf = op_start && clears_results(code_k);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= OPK_READ;
        else if (op_start)
            mode_q <= code_k;
    end
endmodule

// File: rtl/nsr_result_pipe.sv
module nsr_result_pipe
    import nsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_pf,
    input  logic     op_start,
    input  logic     op_done,
    input  logic     op_fail,
    input  op_kind_e mode_q,
    output pf_pair_t pf_q
);
    pf_pair_t pf_d;
    logic     take_done;

    always_comb begin
        pf_d      = pf_q;
        take_done = op_done && !op_start && (mode_q != OPK_READ);
        if (clr_pf) begin
            pf_d = '0;
        end else if (take_done) begin
            if (mode_q == OPK_CACHE) begin
                pf_d.prev = pf_q.cur;
                pf_d.cur  = op_fail;
            end else begin
                pf_d.cur  = op_fail;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pf_q <= '0;
        else     pf_q <= pf_d;
    end
endmodule

// File: rtl/nsr_status_ctl.sv
module nsr_status_ctl (
    input  logic clk,
    input  logic rst,
    input  logic stat_enter,
    input  logic stat_exit,
    output logic active_q
);
    always_ff @(posedge clk) begin
        if (rst)             active_q <= 1'b0;
        else if (stat_exit)  active_q <= 1'b0;
        else if (stat_enter) active_q <= 1'b1;
    end
endmodule

// File: rtl/nsr_word_build.sv
module nsr_word_build
    import nsr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_q,
    input  logic              wide_mode,
    input  op_kind_e          mode_q,
    input  pf_pair_t          pf_q,
    input  live_in_t          live,
    output logic [WORD_W-1:0] word_q,
    output logic              hi_oe_q
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic [BYTE_W-1:0] low_d;
    logic [WORD_W-1:0] word_d;

    always_comb begin
        low_d = active_q ? build_low(mode_q, pf_q, live) : '0;
    end

    generate
        if (HI_W > 0) begin : g_wide
            always_comb word_d = {{HI_W{1'b0}}, low_d};
        end else begin : g_narrow
            always_comb word_d = low_d;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            hi_oe_q <= 1'b0;
        end else begin
            word_q  <= word_d;
            hi_oe_q <= active_q && wide_mode && (HI_W > 0);
        end
    end
endmodule

// File: rtl/nsr_status_gen.sv
module nsr_status_gen
    import nsr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic [1:0]        op_code,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic              array_busy,
    input  logic              cache_busy,
    input  logic              wp_n,
    input  logic              wide_mode,
    input  logic              stat_enter,
    input  logic              stat_exit,
    output logic [WORD_W-1:0] stat_word,
    output logic              stat_hi_oe
);
    op_kind_e mode_q;
    logic     clr_pf;
    pf_pair_t pf_q;
    logic     active_q;
    live_in_t live;

    always_comb begin
        live.array_busy = array_busy;
        live.cache_busy = cache_busy;
        live.wp_n       = wp_n;
    end

    nsr_mode_track u_mode (
        .clk(clk), .rst(rst), .op_start(op_start), .op_code(op_code),
        .mode_q(mode_q), .clr_pf(clr_pf)
    );

    nsr_result_pipe u_pf (
        .clk(clk), .rst(rst), .clr_pf(clr_pf), .op_start(op_start),
        .op_done(op_done), .op_fail(op_fail), .mode_q(mode_q), .pf_q(pf_q)
    );

    nsr_status_ctl u_ctl (
        .clk(clk), .rst(rst), .stat_enter(stat_enter), .stat_exit(stat_exit),
        .active_q(active_q)
    );

    nsr_word_build #(.WORD_W(WORD_W)) u_word (
        .clk(clk), .rst(rst), .active_q(active_q), .wide_mode(wide_mode),
        .mode_q(mode_q), .pf_q(pf_q), .live(live),
        .word_q(stat_word), .hi_oe_q(stat_hi_oe)
    );
endmodule

// File: rtl/nsr_status_chk.sv
module nsr_status_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              array_busy,
    input logic              cache_busy,
    input logic              wp_n,
    input logic              op_done,
    input logic              op_start,
    input logic              active_q,
    input logic [1:0]        mode_q,
    input logic [WORD_W-1:0] stat_word,
    input logic              stat_hi_oe
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (stat_word == '0) && !stat_hi_oe);

    a_r7_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (stat_word[4:2] == 3'b000) && ((WORD_W <= 8) || (stat_word >> 8) == '0));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !active_q |=> (stat_word == '0) && !stat_hi_oe);

    a_r6_wp_live: assert property (@(posedge clk) disable iff (rst)
        active_q |=> stat_word[7] == $past(wp_n));

    a_r4_true_ready: assert property (@(posedge clk) disable iff (rst)
        active_q |=> stat_word[5] == !$past(array_busy));

    a_r5_host_cache: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q == 2'd3) |=> stat_word[6] == !$past(cache_busy));

    a_r5_host_plain: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q != 2'd3) |=> stat_word[6] == stat_word[5]);

    a_r3_prev_masked: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q != 2'd3) |=> !stat_word[1]);

    a_r2_read_masked: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q == 2'd0) |=> !stat_word[0]);
endmodule

bind nsr_status_gen nsr_status_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .array_busy(array_busy), .cache_busy(cache_busy),
    .wp_n(wp_n), .op_done(op_done), .op_start(op_start), .active_q(active_q),
    .mode_q(mode_q), .stat_word(stat_word), .stat_hi_oe(stat_hi_oe)
);

// File: tb/sim_nsr_status_gen.sv
`timescale 1ns/1ps
module sim_nsr_status_gen;
    logic clk = 0;
    logic rst = 1;
    logic op_start = 0, op_done = 0, op_fail = 0;
    logic [1:0] op_code = 0;
    logic array_busy = 0, cache_busy = 0, wp_n = 1, wide_mode = 0;
    logic stat_enter = 0, stat_exit = 0;
    logic [15:0] stat_word;
    logic stat_hi_oe;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    nsr_status_gen u0 (
        .clk(clk), .rst(rst), .op_start(op_start), .op_code(op_code),
        .op_done(op_done), .op_fail(op_fail), .array_busy(array_busy),
        .cache_busy(cache_busy), .wp_n(wp_n), .wide_mode(wide_mode),
        .stat_enter(stat_enter), .stat_exit(stat_exit),
        .stat_word(stat_word), .stat_hi_oe(stat_hi_oe)
    );

    // behavioural reference model
    int m_mode = 0;
    int m_cur = 0, m_prev = 0;
    bit m_act = 0;
    logic [15:0] e_word = 0;
    bit e_oe = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cur = 0; m_prev = 0; m_act = 0;
            e_word = 0; e_oe = 0;
        end else begin
            e_word = 0;
            if (m_act) begin
                if (m_mode != 0) e_word[0] = m_cur[0];
                if (m_mode == 3) e_word[1] = m_prev[0];
                e_word[5] = !array_busy;
                e_word[6] = (m_mode == 3) ? !cache_busy : !array_busy;
                e_word[7] = wp_n;
            end
            e_oe = m_act && wide_mode;
            if (op_start) begin
                if (op_code == 1 || op_code == 2) begin m_cur = 0; m_prev = 0; end
                m_mode = op_code;
            end else if (op_done && m_mode != 0) begin
                if (m_mode == 3) m_prev = m_cur;
                m_cur = op_fail;
            end
            if (stat_exit) m_act = 0;
            else if (stat_enter) m_act = 1;
        end
    end

    task automatic check_bit(string req, logic a, logic e);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, a, e, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done_flag) begin
            check_bit("R2 bit0", stat_word[0], e_word[0]);
            check_bit("R3 bit1", stat_word[1], e_word[1]);
            check_bit("R7 bits4:2", |stat_word[4:2], 1'b0);
            check_bit("R4 bit5", stat_word[5], e_word[5]);
            check_bit("R5 bit6", stat_word[6], e_word[6]);
            check_bit("R6 bit7", stat_word[7], e_word[7]);
            check_bit("R7 upper", |stat_word[15:8], 1'b0);
            check_bit("R7 hi_oe", stat_hi_oe, e_oe);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start(int code);
        op_start = 1; op_code = code[1:0]; tick(); op_start = 0;
    endtask

    task automatic pulse_done(bit f);
        op_done = 1; op_fail = f; tick(); op_done = 0; op_fail = 0;
    endtask

    task automatic expect_word(string req, logic [15:0] e);
        checks++;
        if (stat_word !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, stat_word, e);
        end
    endtask

    initial begin
        repeat (3) tick();
        expect_word("R1 reset word", 16'h0000);
        rst = 0; tick();
        expect_word("R1 after reset", 16'h0000);
        // R8 enter status
        stat_enter = 1; tick(); stat_enter = 0; tick();
        expect_word("R8 entered, read mode idle", 16'h00E0);
        // R2 page program fail
        pulse_start(1); array_busy = 1; tick();
        array_busy = 0; pulse_done(1); tick();
        expect_word("R2 program fail", 16'h00E1);
        // R10 erase clears
        pulse_start(2); tick();
        expect_word("R10 erase clears", 16'h00E0);
        pulse_done(0); tick();
        // R3 cache pipeline: fail, pass, fail
        pulse_start(3); cache_busy = 1; array_busy = 1; tick();
        expect_word("R5 cache busy", 16'h0080);
        cache_busy = 0; tick();
        expect_word("R5 cache ready array busy", 16'h00C0);
        pulse_done(1); pulse_done(0); tick();
        expect_word("R3 prev fail cur pass", 16'h00C2);
        pulse_done(1); array_busy = 0; tick();
        expect_word("R3 cur fail prev pass", 16'h00E1);
        // R10 cache start does not clear
        pulse_start(3); tick();
        expect_word("R10 cache start keeps", 16'h00E1);
        // R11 start+done same cycle: done ignored
        op_start = 1; op_code = 1; op_done = 1; op_fail = 1; tick();
        op_start = 0; op_done = 0; op_fail = 0; tick();
        expect_word("R11 done ignored with start", 16'h00E0);
        // R11 done in read mode ignored
        pulse_start(0); pulse_done(1); pulse_start(1); tick();
        expect_word("R11 read done ignored", 16'h00E0);
        // R6 protect, R7 wide
        wp_n = 0; wide_mode = 1; tick(); tick();
        expect_word("R6 protected", 16'h0060);
        check_bit("R7 hi_oe wide", stat_hi_oe, 1'b1);
        // R8 enter+exit together: exit wins
        stat_enter = 1; stat_exit = 1; tick(); stat_enter = 0; stat_exit = 0; tick();
        expect_word("R8 exit wins", 16'h0000);
        // R9 live updates while active
        stat_enter = 1; tick(); stat_enter = 0; wp_n = 1; tick();
        expect_word("R9 live wp", 16'h00E0);
        array_busy = 1; tick();
        expect_word("R9 live busy", 16'h0080);
        // random sweep
        for (int i = 0; i < 3000; i++) begin
            op_start   = ($urandom % 12) == 0;
            op_code    = $urandom;
            op_done    = ($urandom % 6) == 0;
            op_fail    = $urandom;
            array_busy = $urandom;
            cache_busy = $urandom;
            wp_n       = $urandom;
            wide_mode  = $urandom;
            stat_enter = ($urandom % 8) == 0;
            stat_exit  = ($urandom % 20) == 0;
            rst        = ($urandom % 500) == 0;
            tick();
        end
        rst = 1; tick(); rst = 0; tick();
        expect_word("R1 final reset", 16'h0000);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule